// File: doc/BRIEF.md
# Torus Mesh Neighbour Shift Network

This block moves a vector of sixteen data words, one per processing element, across a 4 by 4 mesh whose edges wrap around. The elements are numbered 0 to 15 in row order. On each step the whole vector goes through one of four fixed permutations: a shift by one element forward, a shift by one element back, a shift by a whole row forward or a shift by a whole row back. Every index is taken modulo 16.

The network has a single stage. A longer move sends the vector back through the same permutation several times. A command carries a function code, a hop count and the sixteen input words. It is taken in while the block is idle, and the block then recirculates the vector once per clock until the hop count is used up. It then raises a one-cycle done strobe. The final vector remains on the result port until the next command is taken.

Top module: `torusShiftNet`

## Requirements
- R1: After reset, cmdReady is 1, resDone is 0 and resData is all zeros.
- R2: A command is accepted on a rising edge where cmdValid and cmdReady are both 1. The sixteen words on cmdData are captured at that edge. Word i sits in bits [8i+7:8i].
- R3: Function code 00 moves the word held by element i to element (i+1) mod 16 on each hop.
- R4: Function code 01 moves the word held by element i to element (i-1) mod 16 on each hop.
- R5: Function code 10 moves the word held by element i to element (i+4) mod 16 on each hop.
- R6: Function code 11 moves the word held by element i to element (i-4) mod 16 on each hop.
- R7: For a hop count h from 1 to 15, resDone is 1 in the cycle that follows the h-th rising edge after the accepting edge. At that point resData equals the chosen permutation applied h times to the captured vector.
- R8: While a move is in progress, cmdReady is 0. Any cmdValid seen during the move has no effect on the timing or the value of the result.
- R9: resDone is high for exactly one cycle. resData then stays stable until the next command is accepted.
- R10: A hop count of 0 raises resDone in the cycle after the accepting edge, and resData equals the captured vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | High while idle; a command is taken when both are high |
| cmdFn | input | 2 | Routing function: 00 +1, 01 -1, 10 +row, 11 -row |
| cmdHops | input | 4 | Number of recirculation hops, 0 to 15 |
| cmdData | input | 128 | Sixteen 8-bit words; word i in bits [8i+7:8i] |
| resDone | output | 1 | One-cycle strobe when the move completes |
| resData | output | 128 | Current vector in the network; the result after resDone |

## Verification
If the hop counter holds a wrong value, resDone arrives early or late. The bench counts cycles from acceptance, so the very first multi-hop move shows this. If the function register or a routing wire is wrong, the first result word with a different neighbour mismatches, and this is caught in the single-hop tests. A busy state that leaks into acceptance shows up as a corrupted vector or a shifted done time after the bench drives commands into a move that is in progress. A hold path that drifts shows up as resData changing in the cycles after resDone.

// File: rtl/torusShiftPkg.sv
package torusShiftPkg;
  localparam int unsigned ELEM_W   = 8;
  localparam int unsigned NUM_ELEM = 16;
  localparam int unsigned ROW_LEN  = 4;
  localparam int unsigned HOP_W    = 4;

  typedef enum logic [1:0] {
    FN_INC     = 2'b00,
    FN_DEC     = 2'b01,
    FN_ROW_INC = 2'b10,
    FN_ROW_DEC = 2'b11
  } routeFn_e;

  typedef struct packed {
    logic     load;
    logic     step;
    routeFn_e fn;
  } pathCtl_t;
endpackage

// File: rtl/torusShiftPath.sv
module torusShiftPath
  import torusShiftPkg::*;
#(
  parameter int unsigned N = NUM_ELEM,
  parameter int unsigned R = ROW_LEN,
  parameter int unsigned W = ELEM_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  pathCtl_t       ctl,
  input  logic [N*W-1:0] loadData,
  output logic [N*W-1:0] curData
);
  localparam int unsigned VEC_W = N * W;

  logic [VEC_W-1:0] plusOne;
  logic [VEC_W-1:0] minusOne;
  logic [VEC_W-1:0] plusRow;
  logic [VEC_W-1:0] minusRow;
  logic [VEC_W-1:0] nextVec;

  // destination j gathers from the source that lands on it
  for (genvar j = 0; j < N; j++) begin : g_route
    assign plusOne[j*W +: W]  = curData[((j + N - 1) % N)*W +: W];
    assign minusOne[j*W +: W] = curData[((j + 1) % N)*W +: W];
    assign plusRow[j*W +: W]  = curData[((j + N - R) % N)*W +: W];
    assign minusRow[j*W +: W] = curData[((j + R) % N)*W +: W];
  end

  always_comb begin
    unique case (ctl.fn)
      FN_INC:     nextVec = plusOne;
      FN_DEC:     nextVec = minusOne;
      FN_ROW_INC: nextVec = plusRow;
      default:    nextVec = minusRow;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          curData <= '0;
    else if (ctl.load)  curData <= loadData;
    else if (ctl.step)  curData <= nextVec;
  end

  // R3
  plus_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load && ctl.fn == FN_INC) |=> curData[W +: W] == $past(curData[0 +: W]));

  // R6
  minus_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load && ctl.fn == FN_ROW_DEC) |=> curData[0 +: W] == $past(curData[R*W +: W]));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(curData));
endmodule

// File: rtl/torusShiftCtrl.sv
module torusShiftCtrl
  import torusShiftPkg::*;
#(
  parameter int unsigned HW = HOP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdFn,
  input  logic [HW-1:0] cmdHops,
  output logic          cmdReady,
  output logic          resDone,
  output pathCtl_t      ctl
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e        state;
  logic [HW-1:0] hopsLeft;
  routeFn_e      fnReg;
  logic          doneReg;
  logic          accept;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign resDone  = doneReg;

  always_comb begin
    ctl.load = accept;
    ctl.step = (state == ST_RUN);
    ctl.fn   = fnReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hopsLeft <= '0;
      fnReg    <= FN_INC;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            fnReg    <= routeFn_e'(cmdFn);
            hopsLeft <= cmdHops;
            if (cmdHops == '0) doneReg <= 1'b1;
            else               state   <= ST_RUN;
          end
        end
        default: begin
          hopsLeft <= hopsLeft - HW'(1);
          if (hopsLeft == HW'(1)) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
      endcase
    end
  end

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && hopsLeft != HW'(1)) |=> (state == ST_RUN && hopsLeft == $past(hopsLeft) - HW'(1)));

  // R8
  fn_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> fnReg == $past(fnReg));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && !(cmdValid && cmdHops == '0)) |=> !resDone);

  // R10
  zero_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdHops == '0) |=> (resDone && state == ST_IDLE));
endmodule

// File: rtl/torusShiftNet.sv
module torusShiftNet
  import torusShiftPkg::*;
#(
  parameter int unsigned NUM_ELEM_P = NUM_ELEM,
  parameter int unsigned ROW_LEN_P  = ROW_LEN,
  parameter int unsigned ELEM_W_P   = ELEM_W,
  parameter int unsigned HOP_W_P    = HOP_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic [1:0]                   cmdFn,
  input  logic [HOP_W_P-1:0]           cmdHops,
  input  logic [NUM_ELEM_P*ELEM_W_P-1:0] cmdData,
  output logic                         resDone,
  output logic [NUM_ELEM_P*ELEM_W_P-1:0] resData
);
  pathCtl_t pathCtl;

  torusShiftCtrl #(.HW(HOP_W_P)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdFn    (cmdFn),
    .cmdHops  (cmdHops),
    .cmdReady (cmdReady),
    .resDone  (resDone),
    .ctl      (pathCtl)
  );

  torusShiftPath #(.N(NUM_ELEM_P), .R(ROW_LEN_P), .W(ELEM_W_P)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (pathCtl),
    .loadData (cmdData),
    .curData  (resData)
  );

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> cmdReady);
endmodule

// File: tb/test_torusShiftNet.sv
module test_torusShiftNet;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdReady;
  logic [1:0]   cmdFn = 2'b00;
  logic [3:0]   cmdHops = 4'd0;
  logic [127:0] cmdData = '0;
  logic         resDone;
  logic [127:0] resData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  torusShiftNet i_torusShiftNet (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdFn(cmdFn), .cmdHops(cmdHops), .cmdData(cmdData),
    .resDone(resDone), .resData(resData)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mkVec(input int seed);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(seed + i * 37);
    return v;
  endfunction

  function automatic logic [127:0] refRoute(input logic [127:0] v, input logic [1:0] fn, input int hops);
    logic [127:0] cur = v;
    logic [127:0] nxt;
    int s;
    case (fn)
      2'b00: s = 1;
      2'b01: s = 15;
      2'b10: s = 4;
      default: s = 12;
    endcase
    for (int h = 0; h < hops; h++) begin
      for (int j = 0; j < 16; j++) nxt[j*8 +: 8] = cur[((j + 16 - s) % 16)*8 +: 8];
      cur = nxt;
    end
    return cur;
  endfunction

  // issue a command, optionally poke cmdValid during the move, and check timing and data
  task automatic runMove(input logic [1:0] fn, input int hops, input logic [127:0] data,
                         input string req, input bit poke);
    int waited = 0;
    logic [127:0] exp = refRoute(data, fn, hops);
    @(negedge clk);
    check(cmdReady == 1'b1, "R2", 128'(cmdReady), 128'(1));
    cmdValid = 1'b1; cmdFn = fn; cmdHops = 4'(hops); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    if (hops > 0) check(cmdReady == 1'b0, "R8", 128'(cmdReady), 128'(0));
    while (!resDone && waited < 40) begin
      if (poke && waited < 3) begin
        cmdValid = 1'b1; cmdFn = ~fn; cmdHops = 4'd1; cmdData = ~data;
        check(cmdReady == 1'b0, "R8", 128'(cmdReady), 128'(0));
      end else cmdValid = 1'b0;
      @(negedge clk);
      waited++;
    end
    cmdValid = 1'b0;
    check(waited == hops, hops == 0 ? "R10" : "R7", 128'(waited), 128'(hops));
    check(resData == exp, req, resData, exp);
    if (poke) check(resData == exp, "R8", resData, exp);
  endtask

  task automatic tReset();
    check(cmdReady == 1'b1, "R1", 128'(cmdReady), 128'(1));
    check(resDone == 1'b0, "R1", 128'(resDone), 128'(0));
    check(resData == '0, "R1", resData, '0);
  endtask

  task automatic tSingle();
    runMove(2'b00, 1, mkVec(3), "R3", 1'b0);
    runMove(2'b01, 1, mkVec(11), "R4", 1'b0);
    runMove(2'b10, 1, mkVec(29), "R5", 1'b0);
    runMove(2'b11, 1, mkVec(90), "R6", 1'b0);
  endtask

  task automatic tMulti();
    runMove(2'b00, 15, mkVec(5), "R7", 1'b0);
    runMove(2'b10, 4, mkVec(7), "R7", 1'b0);
    check(resData == mkVec(7), "R5", resData, mkVec(7));
    runMove(2'b11, 3, mkVec(44), "R7", 1'b0);
    runMove(2'b01, 7, mkVec(61), "R7", 1'b0);
  endtask

  task automatic tBusy();
    runMove(2'b10, 8, mkVec(123), "R8", 1'b1);
  endtask

  task automatic tHold();
    logic [127:0] snap;
    runMove(2'b00, 2, mkVec(200), "R9", 1'b0);
    snap = resData;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(resDone == 1'b0, "R9", 128'(resDone), 128'(0));
      check(resData == snap, "R9", resData, snap);
    end
  endtask

  task automatic tZero();
    runMove(2'b01, 0, mkVec(77), "R10", 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    tReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSingle();
    tMulti();
    tBusy();
    tHold();
    tZero();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule